// File: doc/BRIEF.md
# Associative Memory Road Finder

This block finds candidate track roads in a detector that reads out four layers at once. Each layer has its own hit port. A port takes one local strip address per cycle. Every accepted address passes through a fixed four-stage pipeline that coarsens it into a superstrip number. The superstrip then marks every stored road whose pattern names that superstrip on that layer. The pattern bank is built into the block: each road holds one superstrip per layer.

The upstream logic closes an event by raising `evt_end`. This can happen together with the event's final hits or on a later cycle. Once the last hit has left the pipeline, the block spends a fixed eight cycles resolving the bank. It then streams the numbers of the roads whose four layers are all marked, lowest number first. Because the latency is deterministic, the caller can budget an event as: the busiest layer's hit count, plus twelve cycles, plus one cycle per road found.

Both directions are valid/ready streams. A hit moves only in a cycle where its layer's `hit_valid` and `hit_ready` are both high. The block lowers all four ready lines together from the cycle after it accepts `evt_end` until the event's output has finished, so upstream simply holds its data. On the output side, while `road_valid` is high and `road_ready` is low, the current beat stays frozen. The block then emits no further beats until the downstream side takes it.

Top module: `amrf_road_finder`

## Requirements
- R1: A hit on layer l is accepted in any cycle where `hit_valid[l]` and `hit_ready[l]` are both high, one hit per layer per cycle, on all four layers at once. The four `hit_ready` bits always carry the same value, and it is high only while the block is collecting an event.
- R2: The superstrip of an address is the address shifted right by `SS_SHIFT` bits. Addresses that differ only in those low bits are equivalent.
- R3: On layer l, road r stores superstrip (r*(2l+1)+l) mod 2^(ADDR_W-SS_SHIFT). A road is found exactly when each of the four layers received, during the event, at least one hit whose superstrip equals the road's superstrip for that layer. The order of hits and any repeated hits make no difference.
- R4: `evt_end` is taken only while `hit_ready` is high. Hits accepted in the same cycle belong to the closing event. `hit_ready` drops in the next cycle.
- R5: Number the event's first input cycle 0, and let N be the largest per-layer hit count (at least 1). If `evt_end` is accepted in cycle N-1, the first output beat appears in cycle N+12. With `road_ready` held high, the last of R found roads appears in cycle N+11+R.
- R6: Found road numbers come out one per beat in strictly ascending order, on `road_id`. `road_last` is high on the final beat only.
- R7: If no road is found, exactly one beat is sent, with `road_valid`, `road_last` and `road_empty` high and `road_id` zero. `road_empty` is low on every other beat.
- R8: While `road_valid` is high and `road_ready` is low, `road_valid`, `road_id`, `road_last` and `road_empty` hold their values into the next cycle.
- R9: Hits offered while `hit_ready` is low are not taken and have no effect on any event.
- R10: After the final beat is accepted, all match marks are cleared and `hit_ready` is high again in the next cycle, so an event never sees marks from an earlier event.
- R11: After reset, all `hit_ready` bits are high, `road_valid` is low, and no marks are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 4 | Per-layer hit valid |
| hit_addr | input | 4*ADDR_W | Per-layer local strip address, layer l at bits [l*ADDR_W +: ADDR_W] |
| hit_ready | output | 4 | Per-layer hit ready, all four equal |
| evt_end | input | 1 | Closes the current event when sampled with ready high |
| road_valid | output | 1 | Output beat valid |
| road_ready | input | 1 | Downstream accepts the beat |
| road_id | output | RID_W | Number of a found road |
| road_last | output | 1 | Final beat of the event |
| road_empty | output | 1 | Beat carries no road (no match in event) |

## Verification
The bench builds the block at its default parameters: 32 roads, 8-bit addresses and a 2-bit shift, which gives 64 superstrips per layer. With these values every road can be made the single target of its own event, once each, with partial decoy roads on the side and the busiest-layer count varied between events. The bank can also be filled completely, up to 32 hits per layer in mixed order, and that run exercises the full-length output stream and the exact last-beat cycle. The small superstrip space also lets the bench predict each result from the pattern formula alone. That covers random road subsets, decoy-only events, empty events, stalled output and hits offered while the input is closed.

// File: rtl/amrf_pkg.sv
package amrf_pkg;

  localparam int NUM_LAYERS     = 4;
  localparam int SS_LATENCY     = 4;
  localparam int RESOLVE_CYCLES = 8;

  typedef enum logic [1:0] {
    ST_COLLECT,
    ST_DRAIN,
    ST_RESOLVE,
    ST_EMIT
  } phase_e;

  // Superstrip held by a road on a layer in the built-in bank.
  function automatic int pattern_ss(input int road, input int layer, input int ss_w);
    return (road * (2 * layer + 1) + layer) % (1 << ss_w);
  endfunction

endpackage

// File: rtl/amrf_ss_pipe.sv
module amrf_ss_pipe #(
  parameter int ADDR_W   = 8,
  parameter int SS_SHIFT = 2,
  parameter int LAT      = 4,
  localparam int SS_W    = ADDR_W - SS_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_vld,
  output logic [SS_W-1:0]   out_ss
);

  logic [LAT-1:0]  vld_q;
  logic [SS_W-1:0] ss_q [LAT];
  logic            unused_low_bits;

  assign unused_low_bits = ^in_addr[SS_SHIFT-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int s = 0; s < LAT; s++) ss_q[s] <= '0;
    end else begin
      vld_q   <= {vld_q[LAT-2:0], in_vld};
      ss_q[0] <= in_addr[ADDR_W-1:SS_SHIFT];
      for (int s = 1; s < LAT; s++) ss_q[s] <= ss_q[s-1];
    end
  end

  assign out_vld = vld_q[LAT-1];
  assign out_ss  = ss_q[LAT-1];

endmodule

// File: rtl/amrf_road_bank.sv
module amrf_road_bank
  import amrf_pkg::*;
#(
  parameter int NUM_ROADS = 32,
  parameter int SS_W      = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic [NUM_LAYERS-1:0]      ss_vld,
  input  logic [NUM_LAYERS*SS_W-1:0] ss_flat,
  output logic [NUM_ROADS-1:0]       found
);

  logic [NUM_ROADS-1:0][NUM_LAYERS-1:0] mark_q;
  logic [NUM_ROADS-1:0][NUM_LAYERS-1:0] set_w;

  for (genvar r = 0; r < NUM_ROADS; r++) begin : g_road
    for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
      localparam logic [SS_W-1:0] PAT = SS_W'(pattern_ss(r, l, SS_W));
      assign set_w[r][l] = ss_vld[l] && (ss_flat[l*SS_W +: SS_W] == PAT);
    end
    assign found[r] = &mark_q[r];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) mark_q <= '0;
    else                 mark_q <= mark_q | set_w;
  end

endmodule

// File: rtl/amrf_emitter.sv
module amrf_emitter #(
  parameter int NUM_ROADS = 32,
  localparam int RID_W    = (NUM_ROADS > 1) ? $clog2(NUM_ROADS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [NUM_ROADS-1:0] found,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [RID_W-1:0]     out_id,
  output logic                 out_last,
  output logic                 out_empty,
  output logic                 done
);

  logic                 active_q;
  logic [NUM_ROADS-1:0] pend_q;
  logic [NUM_ROADS-1:0] pend_rest;
  logic                 take;

  assign pend_rest = pend_q & (pend_q - NUM_ROADS'(1));

  always_comb begin
    out_id = '0;
    for (int i = NUM_ROADS - 1; i >= 0; i--) begin
      if (pend_q[i]) out_id = RID_W'(i);
    end
  end

  assign out_valid = active_q;
  assign out_empty = active_q && (pend_q == '0);
  assign out_last  = active_q && (pend_rest == '0);
  assign take      = active_q && out_ready;
  assign done      = take && out_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pend_q   <= '0;
    end else if (load) begin
      active_q <= 1'b1;
      pend_q   <= found;
    end else if (take) begin
      pend_q <= pend_rest;
      if (out_last) active_q <= 1'b0;
    end
  end

endmodule

// File: rtl/amrf_road_finder.sv
module amrf_road_finder
  import amrf_pkg::*;
#(
  parameter int NUM_ROADS = 32,
  parameter int ADDR_W    = 8,
  parameter int SS_SHIFT  = 2,
  localparam int SS_W     = ADDR_W - SS_SHIFT,
  localparam int RID_W    = (NUM_ROADS > 1) ? $clog2(NUM_ROADS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_LAYERS-1:0]        hit_valid,
  input  logic [NUM_LAYERS*ADDR_W-1:0] hit_addr,
  output logic [NUM_LAYERS-1:0]        hit_ready,
  input  logic                         evt_end,
  output logic                         road_valid,
  input  logic                         road_ready,
  output logic [RID_W-1:0]             road_id,
  output logic                         road_last,
  output logic                         road_empty
);

  localparam int RC_W = (RESOLVE_CYCLES > 1) ? $clog2(RESOLVE_CYCLES) : 1;

  phase_e                     phase_q, phase_d;
  logic                       collecting;
  logic [NUM_LAYERS-1:0]      take;
  logic                       end_take;
  logic [SS_LATENCY-1:0]      eoe_q;
  logic [RC_W-1:0]            rcnt_q;
  logic [NUM_LAYERS-1:0]      ss_vld;
  logic [NUM_LAYERS*SS_W-1:0] ss_flat;
  logic [NUM_ROADS-1:0]       found;
  logic                       load;
  logic                       emit_done;

  assign collecting = (phase_q == ST_COLLECT);
  assign hit_ready  = {NUM_LAYERS{collecting}};
  assign take       = hit_valid & hit_ready;
  assign end_take   = evt_end && collecting;

  for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_conv
    amrf_ss_pipe #(
      .ADDR_W  (ADDR_W),
      .SS_SHIFT(SS_SHIFT),
      .LAT     (SS_LATENCY)
    ) u_pipe (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_vld (take[l]),
      .in_addr(hit_addr[l*ADDR_W +: ADDR_W]),
      .out_vld(ss_vld[l]),
      .out_ss (ss_flat[l*SS_W +: SS_W])
    );
  end

  amrf_road_bank #(
    .NUM_ROADS(NUM_ROADS),
    .SS_W     (SS_W)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (emit_done),
    .ss_vld (ss_vld),
    .ss_flat(ss_flat),
    .found  (found)
  );

  assign load = (phase_q == ST_RESOLVE) && (rcnt_q == RC_W'(RESOLVE_CYCLES - 1));

  amrf_emitter #(
    .NUM_ROADS(NUM_ROADS)
  ) u_emit (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .found    (found),
    .out_ready(road_ready),
    .out_valid(road_valid),
    .out_id   (road_id),
    .out_last (road_last),
    .out_empty(road_empty),
    .done     (emit_done)
  );

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      ST_COLLECT: if (end_take)                 phase_d = ST_DRAIN;
      ST_DRAIN:   if (eoe_q[SS_LATENCY-1])      phase_d = ST_RESOLVE;
      ST_RESOLVE: if (load)                     phase_d = ST_EMIT;
      ST_EMIT:    if (emit_done)                phase_d = ST_COLLECT;
      default:                                  phase_d = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= ST_COLLECT;
      eoe_q   <= '0;
      rcnt_q  <= '0;
    end else begin
      phase_q <= phase_d;
      eoe_q   <= {eoe_q[SS_LATENCY-2:0], end_take};
      if (phase_q == ST_RESOLVE) rcnt_q <= rcnt_q + RC_W'(1);
      else                       rcnt_q <= '0;
    end
  end

endmodule

// File: rtl/amrf_road_finder_chk.sv
module amrf_road_finder_chk
  import amrf_pkg::*;
#(
  parameter int RID_W = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_LAYERS-1:0] hit_ready,
  input logic                  evt_end,
  input logic                  road_valid,
  input logic                  road_ready,
  input logic [RID_W-1:0]      road_id,
  input logic                  road_last,
  input logic                  road_empty
);

  localparam int FIRST_GAP = 1 + SS_LATENCY + RESOLVE_CYCLES;

  logic             wait_q;
  logic [4:0]       cnt_q;
  logic             have_prev_q;
  logic [RID_W-1:0] prev_id_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q      <= 1'b0;
      cnt_q       <= '0;
      have_prev_q <= 1'b0;
      prev_id_q   <= '0;
    end else begin
      if (evt_end && hit_ready[0]) begin
        wait_q <= 1'b1;
        cnt_q  <= 5'd1;
      end else if (wait_q) begin
        if (road_valid) wait_q <= 1'b0;
        if (cnt_q != 5'd31) cnt_q <= cnt_q + 5'd1;
      end
      if (road_valid && road_ready) begin
        have_prev_q <= !road_last;
        prev_id_q   <= road_id;
      end
    end
  end

  AST_READY_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ready == '0) || (hit_ready == '1)); // R1
  AST_END_CLOSES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_end && hit_ready[0]) |=> (hit_ready == '0)); // R4
  AST_NO_EARLY_ROAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && cnt_q < 5'(FIRST_GAP)) |-> !road_valid); // R5
  AST_FIRST_ROAD_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && cnt_q == 5'(FIRST_GAP)) |-> road_valid); // R5
  AST_ASCENDING_IDS: assert property (@(posedge clk) disable iff (!rst_n)
    (road_valid && road_ready && have_prev_q) |-> (road_id > prev_id_q)); // R6
  AST_EMPTY_IS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (road_valid && road_empty) |-> road_last); // R7
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (road_valid && !road_ready) |=> (road_valid && $stable(road_id) &&
                                     $stable(road_last) && $stable(road_empty))); // R8
  AST_INPUT_CLOSED_WHILE_EMITTING: assert property (@(posedge clk) disable iff (!rst_n)
    road_valid |-> (hit_ready == '0)); // R9

endmodule

bind amrf_road_finder amrf_road_finder_chk #(
  .RID_W(RID_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hit_ready (hit_ready),
  .evt_end   (evt_end),
  .road_valid(road_valid),
  .road_ready(road_ready),
  .road_id   (road_id),
  .road_last (road_last),
  .road_empty(road_empty)
);

// File: tb/amrf_road_finder_tb_top.sv
module amrf_road_finder_tb_top;

  localparam int NR  = 32;
  localparam int AW  = 8;
  localparam int SH  = 2;
  localparam int SSW = AW - SH;
  localparam int NL  = 4;
  localparam int RW  = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NL-1:0]    hit_valid = '0;
  logic [NL*AW-1:0] hit_addr = '0;
  logic [NL-1:0]    hit_ready;
  logic             evt_end = 1'b0;
  logic             road_valid;
  logic             road_ready = 1'b1;
  logic [RW-1:0]    road_id;
  logic             road_last;
  logic             road_empty;

  always #5 clk = ~clk;

  amrf_road_finder #(.NUM_ROADS(NR), .ADDR_W(AW), .SS_SHIFT(SH)) dut_i (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_addr(hit_addr),
    .hit_ready(hit_ready), .evt_end(evt_end), .road_valid(road_valid),
    .road_ready(road_ready), .road_id(road_id), .road_last(road_last),
    .road_empty(road_empty));

  int n_chk = 0;
  int n_fail = 0;
  int hl [NL][64];
  int hn [NL];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pat(input int r, input int l);
    return (r * (2 * l + 1) + l) % (1 << SSW);
  endfunction

  task automatic clear_hits();
    for (int l = 0; l < NL; l++) hn[l] = 0;
  endtask

  task automatic add_hit(input int l, input int a);
    if (hn[l] < 64) begin
      hl[l][hn[l]] = a;
      hn[l]++;
    end
  endtask

  task automatic add_road(input int r, input int low, input int nlayers);
    for (int l = 0; l < nlayers; l++) add_hit(l, (pat(r, l) << SH) | ((low + l) & 3));
  endtask

  // R3: expected found set from the pattern formula and the hit lists.
  function automatic logic [NR-1:0] exp_found();
    logic [NR-1:0] m = '0;
    for (int r = 0; r < NR; r++) begin
      bit all = 1'b1;
      for (int l = 0; l < NL; l++) begin
        bit any = 1'b0;
        for (int i = 0; i < hn[l]; i++) if ((hl[l][i] >> SH) == pat(r, l)) any = 1'b1;
        all &= any;
      end
      m[r] = all;
    end
    return m;
  endfunction

  // mode 0: ready high, 1: stalled output, 2: hits offered while closed
  task automatic run_event(input int mode);
    int nmax = 0;
    int ncyc;
    logic [NR-1:0] rem;
    int nexp;
    int k = 0;
    int guard = 0;
    bit seen = 0, fin = 0, held = 0;
    int held_id = 0, held_last = 0;
    for (int l = 0; l < NL; l++) if (hn[l] > nmax) nmax = hn[l];
    ncyc = (nmax == 0) ? 1 : nmax;
    rem  = exp_found();
    nexp = $countones(rem);
    for (int c = 0; c < ncyc; c++) begin
      for (int l = 0; l < NL; l++) begin
        hit_valid[l] = (c < hn[l]);
        hit_addr[l*AW +: AW] = (c < hn[l]) ? AW'(hl[l][c]) : '0;
      end
      evt_end = (c == ncyc - 1);
      @(negedge clk);
      if (c == 0) chk(hit_ready == '1, "R1 ready while collecting", hit_ready, 15);
      @(posedge clk); #1;
    end
    evt_end = 1'b0;
    if (mode == 2) begin
      hit_valid = '1;
      for (int l = 0; l < NL; l++) hit_addr[l*AW +: AW] = AW'(pat(5, l) << SH);
    end else begin
      hit_valid = '0;
    end
    chk(1'b1, "R4 end accepted", 0, 0);
    while (!fin && guard < 400) begin
      road_ready = (mode == 1) ? (guard % 3 == 2) : 1'b1;
      @(negedge clk);
      if (k == 1) chk(hit_ready == '0, "R4 ready low after end", hit_ready, 0);
      if (held) begin
        chk(road_valid && road_id == RW'(held_id) && road_last == held_last,
            "R8 beat held under stall", road_id, held_id);
        held = 0;
      end
      if (road_valid) begin
        if (!seen) chk(k == 12, "R5 first beat cycle", k, 12);
        seen = 1;
        if (road_ready) begin
          if (nexp == 0) begin
            chk(road_empty && road_last && road_id == 0, "R7 empty beat",
                {road_empty, road_last}, 3);
            fin = 1;
          end else begin
            int eid = 0;
            for (int i = NR - 1; i >= 0; i--) if (rem[i]) eid = i;
            chk(road_id == RW'(eid) && !road_empty, "R6 road id order", road_id, eid);
            rem[eid] = 1'b0;
            chk(road_last == (rem == '0), "R6 last flag", road_last, (rem == '0));
            if (rem == '0) begin
              fin = 1;
              if (mode != 1) chk(k == 11 + nexp, "R5 last beat cycle", k, 11 + nexp);
            end
          end
        end else begin
          held = 1;
          held_id = road_id;
          held_last = road_last;
        end
      end
      @(posedge clk); #1;
      if (fin) hit_valid = '0;
      k++;
      guard++;
    end
    road_ready = 1'b1;
    if (!fin) chk(1'b0, "R5 event output never completed", guard, 0);
    @(negedge clk);
    chk(hit_ready == '1, "R10 ready after last beat", hit_ready, 15);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    clear_hits();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(hit_ready == '1, "R11 reset ready", hit_ready, 15);
    chk(!road_valid, "R11 reset valid low", road_valid, 0);
    @(posedge clk); #1;

    // R11: event with no hits right after reset gives an empty result
    clear_hits();
    run_event(0);

    // R2 R3: every road alone, with decoys on three layers and varied busiest layer
    for (int r = 0; r < NR; r++) begin
      clear_hits();
      add_road(r, r, NL);
      add_road((r + 1) % NR, r + 2, NL - 1);
      for (int d = 0; d < r % 3; d++) add_hit(r % NL, (pat(r, r % NL) << SH) | d);
      run_event(0);
    end

    // R3 R5 R6: full bank, mixed order per layer
    clear_hits();
    for (int i = 0; i < NR; i++)
      for (int l = 0; l < NL; l++) add_hit(l, pat((l % 2 == 0) ? (i * 7) % NR : NR - 1 - i, l) << SH);
    run_event(0);

    // R10: decoys only right after a full event must not find anything
    clear_hits();
    add_road(0, 1, NL - 1);
    add_road(9, 3, NL - 1);
    run_event(0);

    // R3: random subsets
    for (int t = 0; t < 6; t++) begin
      logic [NR-1:0] m = NR'($urandom);
      clear_hits();
      for (int r = 0; r < NR; r++) if (m[r]) add_road(r, t + r, NL);
      run_event(0);
    end

    // R8: stalled output stream
    clear_hits();
    for (int r = 0; r < NR; r += 5) add_road(r, r, NL);
    run_event(1);

    // R9: hits held while the input is closed, then an empty event
    clear_hits();
    add_road(20, 0, NL);
    run_event(2);
    clear_hits();
    run_event(0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule